// File: doc/BRIEF.md
# Fractional-Increment Time-of-Day Counter

This block keeps wall-clock time for a packet timestamping unit. Time is held as a 32-bit nanoseconds field, which always stays below one billion, and a 64-bit seconds field. While the counter runs, each clock cycle adds a programmable step to the time. The step is an unsigned fixed-point number of nanoseconds with a 5-bit integer part and a 27-bit fraction. The fraction builds up in a hidden 27-bit accumulator, and its carry feeds the nanoseconds field. When nanoseconds reach one billion, the counter takes one billion away and adds one to seconds in the same cycle.

Software drives the block through a single-cycle register port. To set the clock rate, software writes a step equal to (10^9 << 27) / f_clk. To trim the frequency, it rewrites the step at run time, within ±5 % of that nominal value. Time is set by staging the two seconds words and then writing the nanoseconds load word, which commits all three at once. Time is read as three words. The nanoseconds word is read first, and that read freezes a matching copy of the seconds for the two reads that follow.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the counter is stopped, the step is zero, time is zero and every readable register returns 0.
- R2: A write with bit 0 set to address 0 starts counting, and a write with bit 0 set to address 1 stops it. Such writes with bit 0 clear have no effect. While stopped and with no load commit, time does not change.
- R3: The step register (address 2) holds nanoseconds per cycle, with the integer part in bits 31:27 and the fraction in bits 26:0. On each running cycle, nanoseconds grow by the integer part plus the carry out of the 27-bit hidden fraction accumulator.
- R4: When nanoseconds plus the step reach 1,000,000,000 or more, that same cycle subtracts 1,000,000,000 and adds one to the 64-bit seconds. Seconds carry across their 32-bit word boundary.
- R5: Writes to address 6 (seconds bits 63:32) and address 5 (seconds bits 31:0) only stage values. A write to address 4 loads that nanoseconds value and both staged seconds words into the counter on the same edge and clears the fraction. A load wins over counting in that cycle.
- R6: Reading address 8 returns nanoseconds and captures the seconds into a shadow. Reads of address 9 (bits 31:0) and address 10 (bits 63:32) return that shadow, so they match the earlier nanoseconds read.
- R7: A new step is first used on the clock edge after the edge that writes it. Changing the step leaves the accumulated fraction untouched.
- R8: Read data is registered and shows the value from before the read edge, one cycle after the read strobe. Address 0 reads the run flag in bit 0, address 2 reads the step, and addresses 4 to 6 read the staged load words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The bench uses a step of 3.5 ns and reads nanoseconds across several runs. This exposes a design that drops or resets the hidden half-nanosecond: it would read 45 or 48 where 45 and then 49 are due. A load near the end of a second, with seconds bits 31:0 all ones, checks both the same-cycle wrap and the carry into the upper seconds word; a design that wrapped late would show a nanosecond value above one billion. A step rewritten while running must add the old step on its own write edge. The bench also writes a step while the counter is stopped and then runs it. That catches a design that applies the step one edge early or that clears the fraction on a step write. A seconds read taken after a rollover must still return the pre-rollover seconds captured by the nanoseconds read, which a design reading live seconds would fail.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    localparam int REG_AW = 4;

    typedef enum logic [REG_AW-1:0] {
        RA_RUN_SET = 4'd0,
        RA_RUN_CLR = 4'd1,
        RA_STEP    = 4'd2,
        RA_LD_NS   = 4'd4,
        RA_LD_SLO  = 4'd5,
        RA_LD_SHI  = 4'd6,
        RA_MON_NS  = 4'd8,
        RA_MON_SLO = 4'd9,
        RA_MON_SHI = 4'd10
    } reg_addr_e;

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              run_o,
    output logic [DATA_W-1:0] step_o,
    output logic [DATA_W-1:0] ld_ns_o,
    output logic [SEC_W-1:0]  ld_sec_o,
    output logic              commit_o,
    output logic [DATA_W-1:0] commit_ns_o
);

    localparam int HI_W = SEC_W - DATA_W;

    typedef struct packed {
        logic              run;
        logic [DATA_W-1:0] step;
        logic [DATA_W-1:0] ld_ns;
        logic [DATA_W-1:0] ld_slo;
        logic [HI_W-1:0]   ld_shi;
    } regs_t;

    regs_t     cur_q, nxt_d;
    reg_addr_e wa;

    always_comb begin
        wa    = reg_addr_e'(addr_i);
        nxt_d = cur_q;
        if (wr_i) begin
            case (wa)
                RA_RUN_SET: if (wdata_i[0]) nxt_d.run = 1'b1;
                RA_RUN_CLR: if (wdata_i[0]) nxt_d.run = 1'b0;
                RA_STEP:    nxt_d.step   = wdata_i;
                RA_LD_NS:   nxt_d.ld_ns  = wdata_i;
                RA_LD_SLO:  nxt_d.ld_slo = wdata_i;
                RA_LD_SHI:  nxt_d.ld_shi = HI_W'(wdata_i);
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign run_o       = cur_q.run;
    assign step_o      = cur_q.step;
    assign ld_ns_o     = cur_q.ld_ns;
    assign ld_sec_o    = {cur_q.ld_shi, cur_q.ld_slo};
    assign commit_o    = wr_i && (wa == RA_LD_NS);
    assign commit_ns_o = wdata_i;

    assert_run_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_RUN_SET && wdata_i[0]) |=> run_o);

    assert_run_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == RA_RUN_CLR && wdata_i[0]) |=> !run_o);

    assert_run_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && (addr_i == RA_RUN_SET || addr_i == RA_RUN_CLR) && !wdata_i[0])
            |=> $stable(run_o));

endmodule

// File: rtl/ptp_tc_accum.sv
module ptp_tc_accum #(
    parameter int          NS_W       = 32,
    parameter int          INT_W      = 5,
    parameter int          FRAC_W     = 27,
    parameter int          SEC_W      = 64,
    parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    run_i,
    input  logic [INT_W+FRAC_W-1:0] step_i,
    input  logic                    commit_i,
    input  logic [NS_W-1:0]         commit_ns_i,
    input  logic [SEC_W-1:0]        commit_sec_i,
    output logic [NS_W-1:0]         ns_o,
    output logic [SEC_W-1:0]        sec_o
);

    localparam int                 STEP_W = INT_W + FRAC_W;
    localparam logic [NS_W:0]      LIMIT  = (NS_W+1)'(NS_PER_SEC);

    typedef struct packed {
        logic [FRAC_W-1:0] frac;
        logic [NS_W-1:0]   ns;
        logic [SEC_W-1:0]  sec;
    } time_t;

    time_t             cur_q, nxt_d;
    logic [FRAC_W:0]   frac_sum;
    logic [NS_W:0]     ns_sum;
    logic              wrap;

    always_comb begin
        frac_sum = {1'b0, cur_q.frac} + {1'b0, step_i[FRAC_W-1:0]};
        ns_sum   = {1'b0, cur_q.ns}
                 + (NS_W+1)'(step_i[STEP_W-1:FRAC_W])
                 + (NS_W+1)'(frac_sum[FRAC_W]);
        wrap     = (ns_sum >= LIMIT);
        nxt_d    = cur_q;
        if (commit_i) begin
            nxt_d.frac = '0;
            nxt_d.ns   = commit_ns_i;
            nxt_d.sec  = commit_sec_i;
        end else if (run_i) begin
            nxt_d.frac = frac_sum[FRAC_W-1:0];
            if (wrap) begin
                nxt_d.ns  = NS_W'(ns_sum - LIMIT);
                nxt_d.sec = cur_q.sec + 1'b1;
            end else begin
                nxt_d.ns  = NS_W'(ns_sum);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign ns_o  = cur_q.ns;
    assign sec_o = cur_q.sec;

    // Holds as long as software only loads nanosecond values below one second.
    assert_ns_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ns < NS_W'(NS_PER_SEC)));

    assert_sec_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !commit_i) |=> (sec_o == $past(sec_o) || sec_o == $past(sec_o) + 1'b1));

    assert_hold_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !commit_i) |=> ($stable(ns_o) && $stable(sec_o) && $stable(cur_q.frac)));

    assert_commit_loads_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (ns_o == $past(commit_ns_i) && sec_o == $past(commit_sec_i)
                      && cur_q.frac == '0));

endmodule

// File: rtl/ptp_tc_readout.sv
module ptp_tc_readout
    import ptp_tc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int SEC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic              run_i,
    input  logic [DATA_W-1:0] step_i,
    input  logic [DATA_W-1:0] ld_ns_i,
    input  logic [SEC_W-1:0]  ld_sec_i,
    input  logic [DATA_W-1:0] ns_i,
    input  logic [SEC_W-1:0]  sec_i,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [SEC_W-1:0]  shadow;
    } rd_t;

    rd_t       cur_q, nxt_d;
    reg_addr_e ra;

    always_comb begin
        ra    = reg_addr_e'(addr_i);
        nxt_d = cur_q;
        if (rd_i) begin
            case (ra)
                RA_RUN_SET: nxt_d.rdata = DATA_W'(run_i);
                RA_STEP:    nxt_d.rdata = step_i;
                RA_LD_NS:   nxt_d.rdata = ld_ns_i;
                RA_LD_SLO:  nxt_d.rdata = ld_sec_i[DATA_W-1:0];
                RA_LD_SHI:  nxt_d.rdata = DATA_W'(ld_sec_i >> DATA_W);
                RA_MON_NS: begin
                    nxt_d.rdata  = ns_i;
                    nxt_d.shadow = sec_i;
                end
                RA_MON_SLO: nxt_d.rdata = cur_q.shadow[DATA_W-1:0];
                RA_MON_SHI: nxt_d.rdata = DATA_W'(cur_q.shadow >> DATA_W);
                default:    nxt_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign rdata_o = cur_q.rdata;

    assert_shadow_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_i && addr_i == RA_MON_NS) |=> (cur_q.shadow == $past(sec_i) && rdata_o == $past(ns_i)));

    assert_shadow_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_i && addr_i == RA_MON_NS) |=> $stable(cur_q.shadow));

    assert_rdata_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter
    import ptp_tc_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          INT_W      = 5,
    parameter int          SEC_W      = 64,
    parameter int unsigned NS_PER_SEC = 1_000_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int FRAC_W = DATA_W - INT_W;

    logic              run;
    logic [DATA_W-1:0] step;
    logic [DATA_W-1:0] ld_ns;
    logic [SEC_W-1:0]  ld_sec;
    logic              commit;
    logic [DATA_W-1:0] commit_ns;
    logic [DATA_W-1:0] ns;
    logic [SEC_W-1:0]  sec;

    ptp_tc_regs #(.DATA_W(DATA_W), .SEC_W(SEC_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_i        (reg_wr),
        .addr_i      (reg_addr),
        .wdata_i     (reg_wdata),
        .run_o       (run),
        .step_o      (step),
        .ld_ns_o     (ld_ns),
        .ld_sec_o    (ld_sec),
        .commit_o    (commit),
        .commit_ns_o (commit_ns)
    );

    ptp_tc_accum #(
        .NS_W       (DATA_W),
        .INT_W      (INT_W),
        .FRAC_W     (FRAC_W),
        .SEC_W      (SEC_W),
        .NS_PER_SEC (NS_PER_SEC)
    ) u_accum (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .step_i       (step),
        .commit_i     (commit),
        .commit_ns_i  (commit_ns),
        .commit_sec_i (ld_sec),
        .ns_o         (ns),
        .sec_o        (sec)
    );

    ptp_tc_readout #(.DATA_W(DATA_W), .SEC_W(SEC_W)) u_readout (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_i     (reg_rd),
        .addr_i   (reg_addr),
        .run_i    (run),
        .step_i   (step),
        .ld_ns_i  (ld_ns),
        .ld_sec_i (ld_sec),
        .ns_i     (ns),
        .sec_i    (sec),
        .rdata_o  (reg_rdata)
    );

endmodule

// File: tb/ptp_time_counter_bench.sv
`timescale 1ns/1ps
module ptp_time_counter_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [3:0] A_SET = 4'd0, A_CLR = 4'd1, A_STEP = 4'd2,
                           A_LNS = 4'd4, A_LSL = 4'd5, A_LSH = 4'd6,
                           A_MNS = 4'd8, A_MSL = 4'd9, A_MSH = 4'd10;

    always #10 clk = ~clk;

    ptp_time_counter u_ptp_time_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    // All tasks start and end at a falling edge.
    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        reg_rd = 1'b1; reg_addr = a;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d (0x%08h) expected %0d (0x%08h)", req, got, got, exp, exp);
        end
    endtask

    // Enable, idle k cycles, disable: k+1 running edges.
    task automatic run_for(input int k);
        wr_reg(A_SET, 32'd1);
        repeat (k) @(negedge clk);
        wr_reg(A_CLR, 32'd1);
    endtask

    task automatic load_time(input logic [31:0] hi, input logic [31:0] lo, input logic [31:0] nsv);
        wr_reg(A_LSH, hi);
        wr_reg(A_LSL, lo);
        wr_reg(A_LNS, nsv);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd_reg(A_SET, v);  check("R1 run flag", v, 0);
        rd_reg(A_STEP, v); check("R1 step", v, 0);
        rd_reg(A_MNS, v);  check("R1 ns", v, 0);
        rd_reg(A_MSL, v);  check("R1 sec lo", v, 0);
        rd_reg(A_MSH, v);  check("R1 sec hi", v, 0);
    endtask

    task automatic t_strobes();
        logic [31:0] v;
        wr_reg(A_STEP, 32'h0800_0000);
        rd_reg(A_STEP, v); check("R8 step readback", v, 32'h0800_0000);
        wr_reg(A_SET, 32'd0);
        rd_reg(A_SET, v);  check("R2 set with bit0 clear ignored", v, 0);
        repeat (4) @(negedge clk);
        rd_reg(A_MNS, v);  check("R2 stopped time holds", v, 0);
        wr_reg(A_SET, 32'd1);
        wr_reg(A_CLR, 32'd0);
        rd_reg(A_SET, v);  check("R2 clear with bit0 clear ignored", v, 1);
        wr_reg(A_CLR, 32'd1);
        rd_reg(A_SET, v);  check("R2 clear stops", v, 0);
    endtask

    task automatic t_fraction();
        logic [31:0] v;
        wr_reg(A_STEP, (32'd3 << 27) | (32'd1 << 26));
        load_time(0, 0, 0);
        run_for(9);
        rd_reg(A_MNS, v); check("R3 ten steps of 3.5", v, 35);
        run_for(2);
        rd_reg(A_MNS, v); check("R3 hidden half ns", v, 45);
        run_for(0);
        rd_reg(A_MNS, v); check("R3 fraction carry", v, 49);
    endtask

    task automatic t_step_change();
        logic [31:0] v;
        wr_reg(A_STEP, (32'd1 << 27) | (32'd1 << 26));
        load_time(0, 0, 0);
        run_for(0);
        rd_reg(A_MNS, v); check("R7 one step of 1.5", v, 1);
        wr_reg(A_STEP, 32'd1 << 26);
        run_for(0);
        rd_reg(A_MNS, v); check("R7 fraction kept over step write", v, 2);
        wr_reg(A_STEP, 32'd1 << 27);
        load_time(0, 0, 0);
        wr_reg(A_SET, 32'd1);
        wr_reg(A_STEP, 32'd3 << 27);
        wr_reg(A_CLR, 32'd1);
        rd_reg(A_MNS, v); check("R7 new step one edge later", v, 4);
    endtask

    task automatic t_rollover();
        logic [31:0] v;
        wr_reg(A_STEP, 32'd4 << 27);
        load_time(32'd0, 32'hFFFF_FFFF, 32'd999_999_990);
        run_for(2);
        rd_reg(A_MNS, v); check("R4 ns wraps", v, 2);
        rd_reg(A_MSL, v); check("R4 sec lo wraps", v, 0);
        rd_reg(A_MSH, v); check("R4 carry into sec hi", v, 1);
    endtask

    task automatic t_load_seq();
        logic [31:0] v;
        wr_reg(A_SET, 32'd1);
        wr_reg(A_CLR, 32'd1);
        load_time(0, 0, 0);
        wr_reg(A_SET, 32'd1);
        load_time(32'h12, 32'h3456, 32'd500);
        wr_reg(A_CLR, 32'd1);
        rd_reg(A_MNS, v); check("R5 load wins then one step", v, 504);
        rd_reg(A_MSL, v); check("R5 sec lo loaded", v, 32'h3456);
        rd_reg(A_MSH, v); check("R5 sec hi loaded", v, 32'h12);
        rd_reg(A_LSL, v); check("R8 staged sec lo readback", v, 32'h3456);
        rd_reg(A_LNS, v); check("R8 staged ns readback", v, 500);
    endtask

    task automatic t_coherent();
        logic [31:0] v;
        wr_reg(A_STEP, 32'd8 << 27);
        load_time(32'd0, 32'd5, 32'd999_999_990);
        wr_reg(A_SET, 32'd1);
        rd_reg(A_MNS, v); check("R6 ns sampled before first step", v, 999_999_990);
        repeat (3) @(negedge clk);
        rd_reg(A_MSL, v); check("R6 shadow sec lo after rollover", v, 5);
        rd_reg(A_MSH, v); check("R6 shadow sec hi", v, 0);
        wr_reg(A_CLR, 32'd1);
        rd_reg(A_MNS, v);
        rd_reg(A_MSL, v); check("R6 fresh capture sees new second", v, 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strobes();
        t_fraction();
        t_step_change();
        t_rollover();
        t_load_seq();
        t_coherent();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule